// File: doc/BRIEF.md
# Protection Region Access Checker

This block decides whether one memory access may go ahead under a set of protection regions. Each access is given by its byte address, its kind (read, write or instruction fetch) and the privilege level it runs at. Every region has an address register, held in 4-byte granule units, and a configuration byte. The configuration byte carries three permission bits, a two-bit matching mode and a lock bit. The block checks all regions in parallel. The lowest-numbered region that matches sets the outcome.

Machine-level accesses pass through an unlocked region whatever its permission bits say. A locked region applies its permissions to machine level as well. Supervisor and user accesses always need the right permission bit. When no region matches, machine level is allowed and lower levels are refused. The checker registers its answer once, so the result appears one clock after the request. It also reports whether a region matched and which region won, so the answer can be traced.

Top module: `prot_region_chk`

## Requirements
- R1: A request sampled at a rising edge with `req_vld` high gives `rsp_vld` high for exactly the following cycle, with `rsp_allow`, `rsp_hit` and `rsp_idx` for that request. A cycle without a request gives `rsp_vld` low after the next edge.
- R2: Region i's configuration byte is `reg_cfg[8i+7:8i]`, with mode in bits 4:3. Mode 0 (disabled) never matches, whatever its address register or permissions hold.
- R3: Mode 1 (range) matches when the granule address `req_addr[AW-1:2]` is at least the address register of region i-1 and below region i's own register. Region 0 uses zero as its lower bound. The range is empty when the lower bound is not below the upper one.
- R4: Mode 2 (single word) matches only the one granule equal to the region's address register.
- R5: Mode 3 (power-of-two block) treats the address register as t trailing one bits above a base. The block covers 2^(t+3) bytes and is aligned to its own size. An all-ones register covers the whole address space.
- R6: When several regions match, the lowest-numbered one decides the result. `rsp_idx` reports its number.
- R7: For user (`req_priv`=0) or supervisor (1) accesses that hit a region, access is granted by a permission bit chosen by the access kind. A read (kind 0) uses bit 0, a write (kind 1) uses bit 1, and a fetch (kind 2) uses bit 2. Kind 3 is granted by no bit.
- R8: A machine-level access (`req_priv`=3) that hits a region whose lock bit 7 is clear is always allowed.
- R9: A machine-level access that hits a region with lock bit 7 set is allowed only under the R7 permission rule.
- R10: With no matching region, `rsp_hit` is 0 and `rsp_idx` is 0. The access is allowed only when `req_priv` is 3.
- R11: While `rst_n` is low, `rsp_vld`, `rsp_allow`, `rsp_hit` and `rsp_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| reg_cfg | input | 8*NREG | Configuration byte per region |
| reg_addr | input | (AW-2)*NREG | Granule address register per region |
| rsp_vld | output | 1 | Result present |
| rsp_allow | output | 1 | Access granted |
| rsp_hit | output | 1 | Some region matched |
| rsp_idx | output | IW | Number of the deciding region |

## Verification
Every result is due in the cycle after its request. The four response outputs are all registered once, at the edge that samples the request. The driver records the cycle number with each expected item. The monitor samples late in each cycle and requires that a response arrive exactly one cycle after the cycle stored with its item. Configuration changes are made only in idle cycles, so each expected value depends only on the request it belongs to.

// File: rtl/prot_region_chk.sv
module prot_region_chk #(
  parameter int NREG = 8,
  parameter int AW   = 34,
  localparam int GW  = AW - 2,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [AW-1:0]      req_addr,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_priv,
  input  logic [8*NREG-1:0]  reg_cfg,
  input  logic [GW*NREG-1:0] reg_addr,
  output logic               rsp_vld,
  output logic               rsp_allow,
  output logic               rsp_hit,
  output logic [IW-1:0]      rsp_idx
);

  logic [GW-1:0]   gran;
  logic [NREG-1:0] match;
  logic [NREG-1:0] unused_rsvd;
  logic            unused_low;

  assign gran       = req_addr[AW-1:2];
  assign unused_low = ^req_addr[1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_rgn
    logic [7:0]    cfg;
    logic [GW-1:0] top;
    logic [GW-1:0] bot;
    logic [GW-1:0] care;

    assign cfg  = reg_cfg[8*i +: 8];
    assign top  = reg_addr[GW*i +: GW];
    assign care = ~(top ^ (top + 1'b1));
    assign unused_rsvd[i] = ^cfg[6:5];

    if (i == 0) begin : g_first
      assign bot = '0;
    end else begin : g_next
      assign bot = reg_addr[GW*(i-1) +: GW];
    end

    always_comb begin
      unique case (cfg[4:3])
        2'd1:    match[i] = (gran >= bot) && (gran < top);
        2'd2:    match[i] = (gran == top);
        2'd3:    match[i] = ((gran ^ top) & care) == '0;
        default: match[i] = 1'b0;
      endcase
    end
  end

  logic [IW-1:0] win;
  logic          found;
  logic [7:0]    wcfg;
  logic          perm;
  logic          is_m;
  logic          allow_d;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        win   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign wcfg = reg_cfg[{win, 3'b000} +: 8];
  assign is_m = (req_priv == 2'b11);

  always_comb begin
    unique case (req_kind)
      2'd0:    perm = wcfg[0];
      2'd1:    perm = wcfg[1];
      2'd2:    perm = wcfg[2];
      default: perm = 1'b0;
    endcase
  end

  assign allow_d = found ? ((is_m && !wcfg[7]) || perm) : is_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_allow <= allow_d;
        rsp_hit   <= found;
        rsp_idx   <= win;
      end
    end
  end

endmodule

// File: rtl/prot_region_chk_sva.sv
module prot_region_chk_sva #(
  parameter int NREG = 8,
  parameter int AW   = 34,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [1:0]        req_kind,
  input logic [1:0]        req_priv,
  input logic [8*NREG-1:0] reg_cfg,
  input logic              rsp_vld,
  input logic              rsp_allow,
  input logic              rsp_hit,
  input logic [IW-1:0]     rsp_idx
);

  logic [8*NREG-1:0] cfg_q;
  logic [1:0]        kind_q;
  logic [1:0]        priv_q;
  logic [7:0]        wcfg_q;
  logic              perm_q;
  logic              mach_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      kind_q <= '0;
      priv_q <= '0;
    end else begin
      cfg_q  <= reg_cfg;
      kind_q <= req_kind;
      priv_q <= req_priv;
    end
  end

  assign wcfg_q = cfg_q[{rsp_idx, 3'b000} +: 8];
  assign mach_q = (priv_q == 2'b11);
  assign perm_q = (kind_q == 2'd0) ? wcfg_q[0] :
                  (kind_q == 2'd1) ? wcfg_q[1] :
                  (kind_q == 2'd2) ? wcfg_q[2] : 1'b0;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld); // R1
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_hit |-> wcfg_q[4:3] != 2'b00); // R2
  AST_SU_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_hit && !mach_q |-> rsp_allow == perm_q); // R7
  AST_M_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_hit && mach_q && !wcfg_q[7] |-> rsp_allow); // R8
  AST_M_LOCKED_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_hit && mach_q && wcfg_q[7] |-> rsp_allow == perm_q); // R9
  AST_MISS_BY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && !rsp_hit |-> (rsp_allow == mach_q) && (rsp_idx == '0)); // R10

endmodule

bind prot_region_chk prot_region_chk_sva #(.NREG(NREG), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
  .req_priv(req_priv), .reg_cfg(reg_cfg), .rsp_vld(rsp_vld),
  .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
);

// File: tb/sim_prot_region_chk.sv
module sim_prot_region_chk;
  localparam int NREG = 8;
  localparam int AW   = 34;
  localparam int GW   = AW - 2;
  localparam int IW   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               req_vld;
  logic [AW-1:0]      req_addr;
  logic [1:0]         req_kind;
  logic [1:0]         req_priv;
  logic [8*NREG-1:0]  reg_cfg;
  logic [GW*NREG-1:0] reg_addr;
  logic               rsp_vld;
  logic               rsp_allow;
  logic               rsp_hit;
  logic [IW-1:0]      rsp_idx;

  prot_region_chk #(.NREG(NREG), .AW(AW)) u0 (.*);

  typedef struct packed {
    logic [31:0]   tag;
    logic          allow;
    logic          hit;
    logic [IW-1:0] idx;
    logic [31:0]   cyc;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] cyc = 0;
  bit          done = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic set_region(input int i, input logic [7:0] c, input logic [GW-1:0] a);
    reg_cfg[8*i +: 8]    = c;
    reg_addr[GW*i +: GW] = a;
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [1:0] k, input logic [1:0] p,
                       input logic al, input logic ht, input logic [IW-1:0] ix,
                       input logic [31:0] tg);
    @(posedge clk);
    #2;
    req_addr = a;
    req_kind = k;
    req_priv = p;
    req_vld  = 1'b1;
    sb.push_back('{tag: tg, allow: al, hit: ht, idx: ix, cyc: cyc});
  endtask

  task automatic idle();
    @(posedge clk);
    #2;
    req_vld = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (rsp_vld) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected response: rsp_vld=1 expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (cyc != e.cyc + 1 || rsp_allow != e.allow || rsp_hit != e.hit || rsp_idx != e.idx) begin
            errors++;
            $display("FAIL %s cyc=%0d allow=%0b hit=%0b idx=%0d expected cyc=%0d allow=%0b hit=%0b idx=%0d",
                     e.tag, cyc, rsp_allow, rsp_hit, rsp_idx, e.cyc + 1, e.allow, e.hit, e.idx);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog expired: run did not end");
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    req_vld  = 1'b1;
    req_addr = '0;
    req_kind = RD;
    req_priv = PM;
    reg_cfg  = '0;
    reg_addr = '0;
    repeat (3) @(posedge clk);
    #6;
    checks++; // R11 outputs stay zero in reset even with a request present
    if ({rsp_vld, rsp_allow, rsp_hit, rsp_idx} != '0) begin
      errors++;
      $display("FAIL R11 reset outputs=%b expected 0", {rsp_vld, rsp_allow, rsp_hit, rsp_idx});
    end
    req_vld = 1'b0;
    @(posedge clk);
    #2;
    rst_n = 1'b1;

    set_region(0, 8'h11, 32'h0000_0100);  // single word, read
    set_region(1, 8'h0B, 32'h0000_0200);  // range, read+write
    set_region(2, 8'h9C, 32'h0000_1007);  // block 64 bytes, fetch, locked
    set_region(3, 8'h07, 32'hFFFF_FFFF);  // disabled with all permissions
    set_region(4, 8'h0F, 32'h0000_3000);  // empty range
    set_region(5, 8'h99, 32'h0000_2000);  // block 8 bytes, read, locked
    set_region(6, 8'h00, 32'h0000_0000);
    set_region(7, 8'h00, 32'h0000_0000);

    issue(34'h400, RD, PU, 1, 1, 0, "R4");      // single word hit
    issue(34'h400, WR, PU, 0, 1, 0, "R6");      // region 0 wins over region 1
    issue(34'h404, WR, PS, 1, 1, 1, "R3");      // range interior
    issue(34'h7FC, WR, PU, 1, 1, 1, "R3");      // last granule below top
    issue(34'h800, RD, PU, 0, 0, 0, "R3");      // top is exclusive
    issue(34'h3FC, RD, PU, 0, 0, 0, "R3");      // below lower bound
    issue(34'h403, FE, PU, 0, 1, 0, "R7");      // no fetch bit
    issue(34'h403, FE, PM, 1, 1, 0, "R8");      // machine bypasses unlocked
    issue(34'h4000, FE, PU, 1, 1, 2, "R5");     // block base
    issue(34'h403C, FE, PU, 1, 1, 2, "R5");     // block last word
    issue(34'h4040, FE, PU, 0, 0, 0, "R5");     // just past block
    issue(34'h4000, RD, PM, 0, 1, 2, "R9");     // locked, no read bit
    issue(34'h4000, FE, PM, 1, 1, 2, "R9");     // locked, fetch bit set
    issue(34'h1000, RD, PU, 0, 0, 0, "R2");     // disabled region and empty range ignored
    issue(34'h1000, RD, PM, 1, 0, 0, "R10");    // miss at machine level
    issue(34'h800, WR, PS, 0, 0, 0, "R10");     // miss at supervisor level
    issue(34'h8004, WR, PS, 0, 1, 5, "R7");     // 8-byte block, no write bit
    issue(34'h8008, RD, PS, 0, 0, 0, "R5");     // past 8-byte block
    issue(34'h8000, RD, PU, 1, 1, 5, "R5");     // inside 8-byte block
    issue(34'h8000, WR, PM, 0, 1, 5, "R9");     // locked blocks machine write
    issue(34'h400, 2'd3, PU, 0, 1, 0, "R7");    // kind 3 granted by nothing
    issue(34'h3_FFFF_FFFC, RD, PU, 0, 0, 0, "R2"); // disabled all-ones register
    idle();
    repeat (2) @(posedge clk);
    #6;
    checks++; // R1 no response in idle cycles
    if (rsp_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle rsp_vld=%0b expected 0", rsp_vld);
    end

    set_region(0, 8'h09, 32'h0000_0010);  // range from zero, read
    set_region(7, 8'h1F, 32'hFFFF_FFFF);  // block covering everything
    issue(34'h0, RD, PU, 1, 1, 0, "R3");        // region 0 lower bound is zero
    issue(34'h3C, RD, PU, 1, 1, 0, "R3");
    issue(34'h40, WR, PU, 1, 1, 1, "R3");       // region 1 now starts at 0x10
    issue(34'h800, WR, PU, 1, 1, 7, "R5");      // all-ones block catches it
    issue(34'h3_FFFF_FFFC, FE, PS, 1, 1, 7, "R5");
    issue(34'h4000, WR, PU, 0, 1, 2, "R6");     // region 2 still ahead of 7
    idle();
    repeat (3) @(posedge clk);
    checks++; // R1 every request answered
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses=%0d expected 0", sb.size());
    end
    summary();
  end
endmodule